// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block controls one general-purpose I/O port of `WIDTH` pins (eight by default) from a small register bus. Software writes an output-value register and a direction register. The block drives a per-pin output enable and output value toward the pads. It also samples the pad levels through a multi-flop synchronizer. A third, read-only register reports the port state. For each pin, that register shows the written output value if the pin is an output, and the live, synchronized pad level if the pin is an input.

The block treats resets and low-power states in two classes. A power-on reset, or an active hardware-standby input, clears both writable registers, so every pin becomes an input. A manual reset or a software-standby state leaves both registers exactly as they were and blocks bus writes until the condition ends. Reads are registered: data appears on the cycle after the read request and holds until the next read.

Top module: `gpio_port_regs`

## Requirements
- R1: The output-value register is at address 0. A bus write there stores `bus_wdata`, and a later read at address 0 returns the stored value.
- R2: `por_n` low (asynchronous) clears the output-value and direction registers to all zeros. So does `hw_stby` high at a clock edge.
- R3: While `mrst_n` is low or `sw_stby` is high, bus writes are ignored and both registers keep their contents. After the condition ends, the earlier values are still read back and driven.
- R4: A read at address 2 returns, per bit, the output-value bit where the direction bit is 1 and the synchronized pad bit where the direction bit is 0.
- R5: A bus write to address 2 changes neither register, `pad_out` nor `pad_oe`.
- R6: Pad inputs pass through `SYNC_STAGES` (default 2) flops. With the default, a pad change made before clock edge 1 is not visible to an address-2 read sampled at edge 2. It is visible to a read sampled at edge 3.
- R7: The direction register is at address 1 and is write-only. A 1 bit makes that pin an output. `pad_oe` equals the direction register and `pad_out` equals the output-value register.
- R8: While `hw_stby` is high, `pad_oe` is all zeros in the same cycle, with no clock edge needed.
- R9: `bus_rdata` updates only at an edge where `bus_re` is high, and holds otherwise. A read at address 1 returns all ones, a read at address 3 returns all zeros, and `bus_rdata` is zero after power-on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low; retains registers, blocks writes |
| hw_stby | input | 1 | Hardware standby; clears registers, forces outputs disabled |
| sw_stby | input | 1 | Software standby; retains registers, blocks writes |
| bus_addr | input | 2 | Register select: 0 output value, 1 direction, 2 port state |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output value |

## Verification
Register writes take effect at the accepting edge. `pad_out` and `pad_oe` are therefore checked at the following falling edge, and the `hw_stby` override of `pad_oe` is checked in the same cycle it is raised. Read data is due one edge after the request: the bench raises `bus_re` at a falling edge and samples `bus_rdata` at the next falling edge. Pad changes need two edges in the synchronizer before the read edge. The bench places one read at the second edge, where the old level is expected, and one at the third edge, where the new level is expected, to pin down the exact latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned BUS_AW = 2;

   typedef enum logic [BUS_AW-1:0] {
      SEL_VAL  = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_PIN  = 2'd2,
      SEL_NONE = 2'd3
   } gpio_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [SYNC_STAGES];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stg[0] <= '0;
      else        stg[0] <= async_in;
   end

   generate
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign sync_out = stg[LAST];

endmodule

// File: rtl/gpio_port_store.sv
module gpio_port_store
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hw_stby,
   input  logic             wr_ok,
   input  gpio_sel_e        sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] val_q,
   output logic [WIDTH-1:0] dir_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         val_q <= '0;
         dir_q <= '0;
      end else if (hw_stby) begin
         val_q <= '0;
         dir_q <= '0;
      end else if (wr_ok) begin
         case (sel)
            SEL_VAL: val_q <= wdata;
            SEL_DIR: dir_q <= wdata;
            default: ;
         endcase
      end
   end

   // R2: hardware standby empties both registers
   a_r2_hwstby_clears: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |=> (val_q == '0) && (dir_q == '0));

   // R7: an accepted direction write is stored verbatim
   a_r7_dir_write: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ok && !hw_stby && sel == SEL_DIR) |=> dir_q == $past(wdata));

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rd_en,
   input  gpio_sel_e        sel,
   input  logic [WIDTH-1:0] val_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pin_s,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] port_view;
   logic [WIDTH-1:0] rd_next;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign port_view[b] = dir_q[b] ? val_q[b] : pin_s[b];
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_VAL: rd_next = val_q;
         SEL_DIR: rd_next = '1;
         SEL_PIN: rd_next = port_view;
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   // R9: direction address reads as all ones one cycle later
   a_r9_dir_reads_ones: assert property (@(posedge clk) disable iff (!por_n)
      (rd_en && sel == SEL_DIR) |=> rdata == '1);

   // R9: read data holds between reads
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!por_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_port_regs: WIDTH must be at least 1");
      end
   endgenerate

   gpio_sel_e        sel;
   logic             wr_ok;
   logic [WIDTH-1:0] val_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_s;

   assign sel   = gpio_sel_e'(bus_addr);
   assign wr_ok = bus_we && mrst_n && !sw_stby;

   gpio_in_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .por_n    (por_n),
      .async_in (pad_in),
      .sync_out (pin_s)
   );

   gpio_port_store #(.WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .por_n   (por_n),
      .hw_stby (hw_stby),
      .wr_ok   (wr_ok),
      .sel     (sel),
      .wdata   (bus_wdata),
      .val_q   (val_q),
      .dir_q   (dir_q)
   );

   gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
      .clk   (clk),
      .por_n (por_n),
      .rd_en (bus_re),
      .sel   (sel),
      .val_q (val_q),
      .dir_q (dir_q),
      .pin_s (pin_s),
      .rdata (bus_rdata)
   );

   assign pad_out = val_q;
   assign pad_oe  = hw_stby ? '0 : dir_q;

   // R3: manual reset / software standby keep the driven value
   a_r3_retain: assert property (@(posedge clk) disable iff (!por_n)
      ((!mrst_n || sw_stby) && !hw_stby) |=> $stable(pad_out));

   // R5: port-state address is not writable
   a_r5_pin_write_ignored: assert property (@(posedge clk) disable iff (!por_n)
      (bus_we && sel == SEL_PIN && !hw_stby) |=> $stable(pad_out));

   // R1: accepted value write reaches the pads
   a_r1_val_write: assert property (@(posedge clk) disable iff (!por_n)
      (bus_we && mrst_n && !sw_stby && !hw_stby && sel == SEL_VAL)
         |=> pad_out == $past(bus_wdata));

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         por_n = 1'b0;
   logic         mrst_n = 1'b1;
   logic         hw_stby = 1'b0;
   logic         sw_stby = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic         bus_we = 1'b0;
   logic         bus_re = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in = 8'hA5;
   logic [W-1:0] pad_oe;
   logic [W-1:0] pad_out;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   always #5 clk = ~clk;

   gpio_port_regs #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
      .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic chk(input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      bus_addr = a; bus_re = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [W-1:0] d;
      chk("R9 rdata after por", bus_rdata, 8'h00);
      chk("R2 pad_oe after por", pad_oe, 8'h00);
      chk("R2 pad_out after por", pad_out, 8'h00);
      settle(3);
      rd(2'd2, d); chk("R4 port reads pads after por", d, 8'hA5);
      rd(2'd1, d); chk("R7 R9 dir address reads ones", d, 8'hFF);
      rd(2'd3, d); chk("R9 unmapped reads zero", d, 8'h00);
      settle(2);   chk("R9 rdata holds without read", bus_rdata, 8'h00);
   endtask

   task automatic t_val_rw();
      logic [W-1:0] d;
      wr(2'd0, 8'h3C);
      chk("R7 pad_out follows value", pad_out, 8'h3C);
      rd(2'd0, d); chk("R1 value readback", d, 8'h3C);
   endtask

   task automatic t_port_mux();
      logic [W-1:0] d;
      pad_in = 8'h5A;
      wr(2'd1, 8'hF0);
      chk("R7 pad_oe follows dir", pad_oe, 8'hF0);
      settle(2);
      rd(2'd2, d); chk("R4 mixed port read", d, 8'h3A);
      wr(2'd1, 8'hFF);
      rd(2'd2, d); chk("R4 all outputs", d, 8'h3C);
   endtask

   task automatic t_port_write();
      logic [W-1:0] d;
      wr(2'd2, 8'hC3);
      chk("R5 pad_out after port write", pad_out, 8'h3C);
      chk("R5 pad_oe after port write", pad_oe, 8'hFF);
      rd(2'd0, d); chk("R5 value after port write", d, 8'h3C);
   endtask

   task automatic t_sync_latency();
      logic [W-1:0] d;
      wr(2'd1, 8'h00);
      pad_in = 8'h11;
      settle(3);
      pad_in = 8'hEE;               // change before edge 1
      @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R6 not visible at edge 2", d, 8'h11);
      rd(2'd2, d); chk("R6 visible at edge 3", d, 8'hEE);
   endtask

   task automatic t_mrst_retain();
      logic [W-1:0] d;
      wr(2'd1, 8'h0F);
      wr(2'd0, 8'h96);
      mrst_n = 1'b0;
      wr(2'd0, 8'h00); wr(2'd1, 8'hFF);
      settle(2);
      mrst_n = 1'b1;
      settle(1);
      chk("R3 pad_out kept over manual reset", pad_out, 8'h96);
      chk("R3 pad_oe kept over manual reset", pad_oe, 8'h0F);
      rd(2'd0, d); chk("R3 value readback after manual reset", d, 8'h96);
   endtask

   task automatic t_swstby_retain();
      logic [W-1:0] d;
      sw_stby = 1'b1;
      wr(2'd0, 8'h55); wr(2'd1, 8'hF0);
      sw_stby = 1'b0;
      settle(1);
      chk("R3 pad_oe kept over sw standby", pad_oe, 8'h0F);
      rd(2'd0, d); chk("R3 value kept over sw standby", d, 8'h96);
   endtask

   task automatic t_hw_stby();
      logic [W-1:0] d;
      pad_in = 8'h3D;
      hw_stby = 1'b1;
      #1;
      chk("R8 pad_oe low same cycle", pad_oe, 8'h00);
      settle(2);
      hw_stby = 1'b0;
      settle(1);
      chk("R2 pad_oe after hw standby", pad_oe, 8'h00);
      chk("R2 pad_out after hw standby", pad_out, 8'h00);
      rd(2'd0, d); chk("R2 value cleared by hw standby", d, 8'h00);
      rd(2'd2, d); chk("R2 R4 port shows pads after hw standby", d, 8'h3D);
   endtask

   task automatic t_por_midrun();
      logic [W-1:0] d;
      wr(2'd0, 8'hAA); wr(2'd1, 8'hCC);
      #2 por_n = 1'b0;
      #1 chk("R2 async clear of pad_out", pad_out, 8'h00);
      @(negedge clk); por_n = 1'b1;
      settle(1);
      chk("R2 pad_oe after por", pad_oe, 8'h00);
      rd(2'd0, d); chk("R2 value after por", d, 8'h00);
   endtask

   initial begin
      settle(3);
      por_n = 1'b1;
      settle(1);
      t_reset_state();
      t_val_rw();
      t_port_mux();
      t_port_write();
      t_sync_latency();
      t_mrst_retain();
      t_swstby_retain();
      t_hw_stby();
      t_por_midrun();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule